// File: doc/BRIEF.md
# Sensor Exposure and Readout Sequencer

This block drives the exposure window and the readout trigger of a global-shutter area sensor. It either paces frames from its own cycle counter or interprets an external trigger line. The trigger line can be read in three ways: rising edge to rising edge, an active-low level, or a rising edge that opens a window of fixed length set by a register value. A fixed-rate internal mode gives a 60 frames-per-second cadence, derived from the clock-frequency parameter.

The sensor moves all pixel charges into per-pixel storage at once, so a new exposure never has to wait for the previous frame's readout to finish. The sequencer therefore keeps the two apart. The exposure level and the readout-start pulse are independent outputs. A frame counter advances on every readout-start pulse. Mode changes are deferred until the active mode is idle or is issuing a readout, so a running frame is never cut in half.

Top module: `exposure_readout_ctrl`

## Requirements
- R1: The trigger input is resynchronised through two flip-flops before any edge or level decision. A trigger change driven between clock edges first affects the registered outputs at the third rising clock edge after the change.
- R2: Mode code 0 (internal periodic): after the mode becomes active, exposure goes high on the next cycle and stays high. A readout-start pulse occurs every P cycles, where P is the period input sampled at the start of each frame. A P below 2 is treated as 2.
- R3: Mode code 1 (edge to edge): the first synchronised rising edge raises exposure without a readout. Every later rising edge issues a readout-start pulse while exposure stays high.
- R4: Mode code 2 (active-low level): exposure follows the inverted synchronised trigger. The rising edge that ends a low period issues a readout-start pulse in the same cycle that exposure drops.
- R5: Mode code 3 (timed window): a rising edge while idle raises exposure for exactly N cycles, where N is the exposure-length input latched at that edge and a zero N counts as 1. Readout-start is pulsed in the cycle where exposure falls.
- R6: In mode code 3, a rising edge that arrives while a window is open is ignored. It does not extend the window or add a readout, and it raises the overtrigger output for exactly one cycle.
- R7: Mode code 4 (fixed rate) behaves like mode 0, but with a period of CLK_HZ/FRAME_HZ cycles. Codes 5 to 7 behave as mode 0.
- R8: A new mode code is adopted only when the current mode is idle or is issuing a readout-start in that cycle. Until then the old mode keeps running. In the cycle after adoption, exposure is low.
- R9: After reset all outputs are zero. Readout-start never lasts two consecutive cycles. The frame counter increases by one together with each readout-start pulse.
- R10: In mode code 3, a rising edge that is registered in the cycle right after a window expires starts a new window at once. Exposure is then low for only one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Requested mode code (0 periodic, 1 edge, 2 level, 3 timed, 4 fixed rate) |
| trig_i | input | 1 | Asynchronous external trigger |
| expo_len_i | input | CNT_W (20) | Exposure length in cycles for the timed mode |
| period_i | input | CNT_W (20) | Frame period in cycles for the periodic mode |
| expo_active_o | output | 1 | High while the sensor is integrating |
| readout_start_o | output | 1 | One-cycle pulse that starts a frame transfer |
| overtrig_o | output | 1 | One-cycle flag for an ignored trigger in timed mode |
| frame_cnt_o | output | FRAME_W (16) | Count of readout-start pulses |

## Verification
A scoreboard holds the exact cycle of every readout-start pulse the bench expects, so a stray pulse, a missing pulse or one late cycle is caught. The bench fires a retrigger inside an open timed window: a design that reloads the counter would shift the readout, and one that leaves the flag out would miss the overtrigger check. It requests mode changes while edge and periodic modes are busy, so an early switch cuts a frame and moves the readouts. It changes the period and the length in the middle of a frame, which a design without latching would show by shortening the current frame. A zero length, a zero period, and a retrigger right after expiry probe the clamps and show whether the design stalls between windows.

// File: rtl/expo_pkg.sv
// Package: shared mode codes for the exposure/readout sequencer.
// Assumes: mode codes above MODE_FIXED are treated as periodic by the user.
package expo_pkg;
    typedef enum logic [2:0] {
        MODE_FREE  = 3'd0,
        MODE_EDGE  = 3'd1,
        MODE_LEVEL = 3'd2,
        MODE_PROG  = 3'd3,
        MODE_FIXED = 3'd4
    } expo_mode_e;
endpackage

// File: rtl/trig_sync.sv
// Module: trig_sync
// Resynchronises an asynchronous trigger through STAGES flip-flops and
// produces the synchronised level plus a one-cycle rising-edge strobe.
// Assumes: trigger pulses last longer than two clock cycles.
module trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_async,
    output logic trig_lvl,
    output logic trig_rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // First stage samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= trig_async;
    end

    // Remaining stages of the metastability chain.
    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    // Previous synchronised level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign trig_lvl  = chain_q[STAGES-1];
    assign trig_rise = chain_q[STAGES-1] & ~last_q;

    AST_RISE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        trig_rise |=> !trig_rise); // R1
endmodule

// File: rtl/frame_timer.sv
// Module: frame_timer
// Down-counter for exposure windows and frame periods. A load writes the
// value; the count then falls by one per cycle and 'done' marks its last cycle.
// Assumes: load_val is non-zero (the caller clamps it); clear beats load.
module frame_timer #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         running,
    output logic         done
);
    logic [W-1:0] cnt_q;

    assign running = (cnt_q != '0);
    assign done    = (cnt_q == W'(1));

    // Count register: clear, load, or decrement while non-zero.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear)   cnt_q <= '0;
        else if (load)    cnt_q <= load_val;
        else if (running) cnt_q <= cnt_q - W'(1);
    end

    AST_TMR_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> load_val != '0); // R5
    AST_TMR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load && !clear) |=> !running); // R5
endmodule

// File: rtl/frame_counter.sv
// Module: frame_counter
// Wrapping counter of readout-start events.
// Assumes: 'inc' is the pre-register readout strobe, so the count updates
// in the same cycle the registered pulse becomes visible.
module frame_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_q;

    // Advance once per readout event.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (inc) cnt_q <= cnt_q + W'(1);
    end

    assign count = cnt_q;
endmodule

// File: rtl/exposure_readout_ctrl.sv
// Module: exposure_readout_ctrl (top)
// Turns an internal timebase or an external trigger into an exposure level
// and a one-cycle readout-start pulse, in one of five modes. Exposure and
// readout are independent because the sensor has per-pixel storage.
// Assumes: CLK_HZ/FRAME_HZ fits CNT_W bits and is at least 2.
module exposure_readout_ctrl
    import expo_pkg::*;
#(
    parameter int CNT_W    = 20,
    parameter int FRAME_W  = 16,
    parameter int SYNC_STG = 2,
    parameter int CLK_HZ   = 50_000_000,
    parameter int FRAME_HZ = 60
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         mode_i,
    input  logic               trig_i,
    input  logic [CNT_W-1:0]   expo_len_i,
    input  logic [CNT_W-1:0]   period_i,
    output logic               expo_active_o,
    output logic               readout_start_o,
    output logic               overtrig_o,
    output logic [FRAME_W-1:0] frame_cnt_o
);
    localparam int             FIXED_INT = CLK_HZ / FRAME_HZ;
    localparam logic [CNT_W-1:0] FIXED_CYC = CNT_W'(FIXED_INT);
    localparam logic [CNT_W-1:0] MIN_PER   = CNT_W'(2);
    localparam logic [CNT_W-1:0] MIN_EXPO  = CNT_W'(1);

    logic             trig_lvl, trig_rise;
    logic             tmr_running, tmr_done;
    logic             tmr_load, tmr_clear;
    logic [CNT_W-1:0] tmr_val;

    logic [2:0] mode_q;
    logic       expo_q, busy_q, ro_q, ovt_q;
    logic       expo_n, busy_n, ro_n, ovt_n, do_switch;

    trig_sync #(.STAGES(SYNC_STG)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_async(trig_i),
        .trig_lvl  (trig_lvl),
        .trig_rise (trig_rise)
    );

    frame_timer #(.W(CNT_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .load    (tmr_load),
        .load_val(tmr_val),
        .running (tmr_running),
        .done    (tmr_done)
    );

    frame_counter #(.W(FRAME_W)) i_frames (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (ro_n),
        .count(frame_cnt_o)
    );

    // Next-state decisions for the active mode, then the mode-switch override.
    always_comb begin
        expo_n    = expo_q;
        busy_n    = busy_q;
        ro_n      = 1'b0;
        ovt_n     = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = MIN_EXPO;
        tmr_clear = 1'b0;
        case (mode_q)
            MODE_EDGE: begin
                if (trig_rise) begin
                    if (busy_q) ro_n = 1'b1;
                    else begin
                        busy_n = 1'b1;
                        expo_n = 1'b1;
                    end
                end
            end
            MODE_LEVEL: begin
                expo_n = ~trig_lvl;
                busy_n = ~trig_lvl;
                ro_n   = trig_rise & expo_q;
            end
            MODE_PROG: begin
                if (tmr_done) begin
                    ro_n   = 1'b1;
                    expo_n = 1'b0;
                    busy_n = 1'b0;
                    ovt_n  = trig_rise;
                end else if (tmr_running) begin
                    ovt_n = trig_rise;
                end else if (trig_rise) begin
                    tmr_load = 1'b1;
                    tmr_val  = (expo_len_i == '0) ? MIN_EXPO : expo_len_i;
                    expo_n   = 1'b1;
                    busy_n   = 1'b1;
                end
            end
            default: begin
                if (mode_q == MODE_FIXED) tmr_val = FIXED_CYC;
                else tmr_val = (period_i < MIN_PER) ? MIN_PER : period_i;
                if (!busy_q) begin
                    tmr_load = 1'b1;
                    expo_n   = 1'b1;
                    busy_n   = 1'b1;
                end else if (tmr_done) begin
                    tmr_load = 1'b1;
                    ro_n     = 1'b1;
                end
            end
        endcase
        do_switch = (mode_i != mode_q) && (!busy_q || ro_n);
        if (do_switch) begin
            expo_n    = 1'b0;
            busy_n    = 1'b0;
            tmr_clear = 1'b1;
        end
    end

    // State and output registers; reset adopts the requested mode directly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= mode_i;
            expo_q <= 1'b0;
            busy_q <= 1'b0;
            ro_q   <= 1'b0;
            ovt_q  <= 1'b0;
        end else begin
            if (do_switch) mode_q <= mode_i;
            expo_q <= expo_n;
            busy_q <= busy_n;
            ro_q   <= ro_n;
            ovt_q  <= ovt_n;
        end
    end

    assign expo_active_o   = expo_q;
    assign readout_start_o = ro_q;
    assign overtrig_o      = ovt_q;

    AST_RO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        readout_start_o |=> !readout_start_o); // R9
    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        readout_start_o |-> frame_cnt_o == $past(frame_cnt_o) + FRAME_W'(1)); // R9
    AST_PROG_END_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PROG && $fell(expo_active_o)) |-> readout_start_o); // R5
    AST_SWITCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> !expo_active_o); // R8
    AST_OVT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        overtrig_o |-> $past(expo_active_o)); // R6
    AST_OVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        overtrig_o |=> !overtrig_o); // R6
endmodule

// File: tb/test_exposure_readout_ctrl.sv
// Scoreboard bench: the stimulus pushes expected readout cycles into a
// queue; a monitor pops them as readout-start pulses appear.
module test_exposure_readout_ctrl;
    localparam int CW = 20;
    localparam int FW = 16;
    localparam int FIX = 3000 / 60;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    mode = 3'd3;
    logic          trig = 1'b0;
    logic [CW-1:0] elen = CW'(5);
    logic [CW-1:0] per = CW'(6);
    logic          expo, ro, ovt;
    logic [FW-1:0] fcnt;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int n_push = 0;
    bit finished = 1'b0;
    int exp_q[$];

    exposure_readout_ctrl #(.CLK_HZ(3000), .FRAME_HZ(60)) i_exposure_readout_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .trig_i(trig),
        .expo_len_i(elen), .period_i(per), .expo_active_o(expo),
        .readout_start_o(ro), .overtrig_o(ovt), .frame_cnt_o(fcnt));

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp_v);
        end
    endtask

    task automatic at(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic expect_ro(input int t);
        exp_q.push_back(t);
        n_push++;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Monitor: every readout pulse must match the head of the queue.
    always @(negedge clk) begin
        if (rst_n && ro) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R9 unexpected readout: actual cycle %0d expected none", cyc);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != cyc) begin
                    n_fail++;
                    $display("FAIL R9 readout cycle: actual %0d expected %0d", cyc, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int t;
        repeat (3) @(negedge clk);
        chk("R9 reset expo", int'(expo), 0);
        chk("R9 reset ro", int'(ro), 0);
        chk("R9 reset ovt", int'(ovt), 0);
        chk("R9 reset frames", int'(fcnt), 0);
        rst_n = 1'b1;

        // R5 / R1: timed window N=5
        t = cyc + 3; at(t);
        trig = 1'b1; expect_ro(t + 8);
        at(t + 2); trig = 1'b0; chk("R1 not yet", int'(expo), 0);
        at(t + 3); chk("R1 latency", int'(expo), 1);
        at(t + 7); chk("R5 window high", int'(expo), 1);
        at(t + 8); chk("R5 window end", int'(expo), 0); chk("R9 pulse", int'(ro), 1);
        at(t + 9); chk("R9 pulse width", int'(ro), 0);

        // R6: retrigger inside N=20 window
        elen = CW'(20);
        t = t + 12; at(t);
        trig = 1'b1; expect_ro(t + 23);
        at(t + 2); trig = 1'b0;
        at(t + 4); trig = 1'b1;
        at(t + 5); elen = '0;
        at(t + 7); chk("R6 overtrig raised", int'(ovt), 1);
        at(t + 8); chk("R6 overtrig one cycle", int'(ovt), 0);
        at(t + 10); trig = 1'b0;
        at(t + 22); chk("R6 window kept", int'(expo), 1);
        at(t + 23); chk("R5 latched length", int'(expo), 0);

        // R5: zero length counts as one
        t = t + 27; at(t);
        trig = 1'b1; expect_ro(t + 4);
        at(t + 2); trig = 1'b0;
        at(t + 3); chk("R5 zero length high", int'(expo), 1);
        at(t + 4); chk("R5 zero length end", int'(expo), 0);

        // R10: back-to-back windows N=4
        elen = CW'(4);
        t = t + 8; at(t);
        trig = 1'b1; expect_ro(t + 7);
        at(t + 2); trig = 1'b0;
        at(t + 5); trig = 1'b1; expect_ro(t + 12);
        at(t + 7); chk("R10 gap cycle", int'(expo), 0);
        at(t + 8); chk("R10 restart", int'(expo), 1);
        at(t + 9); trig = 1'b0;
        at(t + 12); chk("R10 second end", int'(expo), 0);

        // R3: edge mode, then deferred switch to level (R8), then R4
        t = t + 16; at(t);
        mode = 3'd1;
        at(t + 3); trig = 1'b1;
        at(t + 6); chk("R3 first edge opens", int'(expo), 1);
        at(t + 8); trig = 1'b0;
        at(t + 10); trig = 1'b1; expect_ro(t + 13);
        at(t + 13); chk("R3 stays high at readout", int'(expo), 1);
        at(t + 15); trig = 1'b0;
        at(t + 16); mode = 3'd2;
        at(t + 18); trig = 1'b1; expect_ro(t + 21);
        at(t + 20); chk("R8 old mode still runs", int'(expo), 1);
        at(t + 21); chk("R8 low on switch", int'(expo), 0);
        at(t + 22); chk("R4 idle while high", int'(expo), 0);
        at(t + 24); trig = 1'b0;
        at(t + 27); chk("R4 low level exposes", int'(expo), 1);
        at(t + 30); trig = 1'b1; expect_ro(t + 33);
        at(t + 32); chk("R4 still exposing", int'(expo), 1);
        at(t + 33); chk("R4 ends at rise", int'(expo), 0);

        // R2 / R7 / R8: periodic, period change, fixed rate, clamp
        t = t + 36; at(t);
        mode = 3'd0; per = CW'(6);
        expect_ro(t + 8); expect_ro(t + 14); expect_ro(t + 17); expect_ro(t + 20);
        at(t + 1); chk("R8 idle switch low", int'(expo), 0);
        at(t + 2); chk("R2 starts", int'(expo), 1);
        at(t + 9); per = CW'(3);
        at(t + 14); chk("R2 continuous", int'(expo), 1);
        at(t + 18); mode = 3'd4;
        at(t + 20); chk("R8 switch at readout", int'(expo), 0);
        at(t + 21); chk("R7 fixed starts", int'(expo), 1);
        expect_ro(t + 21 + FIX); expect_ro(t + 21 + 2 * FIX); expect_ro(t + 21 + 3 * FIX);
        at(t + 122); mode = 3'd0; per = '0;
        expect_ro(t + 21 + 3 * FIX + 3); expect_ro(t + 21 + 3 * FIX + 5);
        at(t + 21 + 3 * FIX + 4); mode = 3'd3;
        at(t + 21 + 3 * FIX + 14);
        chk("R9 frame count", int'(fcnt), n_push);
        chk("R2 all readouts seen", exp_q.size(), 0);
        finish_run();
    end
endmodule